// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-facing register file of a four-channel DMA controller. A processor reaches it through an 8-bit data port addressed by a 4-bit offset, with separate read and write strobes. For each channel it keeps a 16-bit address and a 16-bit count. Each of these has a base copy and a working copy. The block also holds a 6-bit mode per channel, a mask bit per channel, a command byte and four terminal-count flags. It passes the working addresses, the modes, the masks and the command byte to the transfer engine. The engine in turn sends back a one-cycle step pulse per channel and its raw request lines.

Offsets 0x0 to 0x7 are 16-bit registers that are reached one byte at a time. A byte-pointer state machine chooses which byte is accessed. In state PTR_LO the low byte is accessed. In state PTR_HI the high byte is accessed. Any read or write at offsets 0x0 to 0x7 moves the machine from PTR_LO to PTR_HI, or from PTR_HI back to PTR_LO. A write to the pointer-reset port (0xC) or to the master-clear port (0xD) forces PTR_LO, and this takes priority over the toggle. Reset also starts the machine in PTR_LO. If read and write are strobed in the same cycle, only the write takes place.

Top module: `dma_host_regs`

## Requirements
- R1: After reset all four mask bits are 1, the command byte is 0x00, every address and count is 0x0000, the terminal-count flags are clear and the byte pointer selects the low byte.
- R2: Channel n (0..3) has its address port at offset 2n and its count port at offset 2n+1. Each read or write of either port accesses the low byte when the pointer is low and the high byte when it is high, then toggles the pointer. Reads return the working copy.
- R3: A write of any data to offset 0xC returns the pointer to the low byte, even in the middle of a 16-bit access.
- R4: A byte written to an address or count port loads both the base and the working copy of that byte.
- R5: A write to offset 0xA changes one mask bit. Data bits 1:0 select the channel. Data bit 2 set masks the channel and data bit 2 clear unmasks it.
- R6: A write to offset 0xB stores data bits 7:2 as the mode of the channel chosen by data bits 1:0. Output ch_mode carries channel n's mode in bits [6n+5:6n].
- R7: A write to offset 0x8 loads the command byte onto cmd_out. A read at offset 0x8 returns the terminal-count flags in bits 3:0 and dreq in bits 7:4, and clears the flags that were read.
- R8: A write to offset 0xD sets all mask bits, returns the pointer to low and clears the command byte and the terminal-count flags. It leaves addresses, counts and modes unchanged. A read at offset 0xD returns 0x00.
- R9: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask bits from data bits 3:0.
- R10: A step pulse on an unmasked channel decrements its working count and moves its working address by one. The address counts down when mode bit 3 (data bit 5 of the mode write) is set, and up otherwise. A step pulse on a masked channel has no effect.
- R11: A step at working count 0x0000 wraps the count to 0xFFFF and sets that channel's terminal-count flag. If mode bit 2 (data bit 4, auto-initialise) is set, the step instead reloads the working address and count from the base copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| dreq | input | 4 | Raw request lines shown in status |
| step | input | 4 | Per-channel transfer step pulse from the engine |
| ch_addr | output | 64 | Working addresses, channel n at [16n+15:16n] |
| ch_mode | output | 24 | Modes, channel n at [6n+5:6n] |
| ch_mask | output | 4 | Mask bit per channel, 1 = masked |
| cmd_out | output | 8 | Command byte |

## Verification
The byte pointer is exercised with writes and with reads alone. It is also tested with a pointer reset inserted between the two halves of a word, which separates a pointer that toggles correctly from one that is stuck or cleared late. Stepping is tried with count-up, count-down, auto-initialise and plain wrap modes, and once more with the channel masked, so that direction, reload and gating each change a different observable value. Master clear is issued while the pointer is high and a terminal-count flag is pending. This shows which state it clears and which it leaves alone.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int NCH    = 4;
    localparam int DW     = 8;
    localparam int WW     = 16;
    localparam int MODEW  = 6;
    localparam int OFSW   = 4;
    localparam int SELW   = $clog2(NCH);

    localparam logic [OFSW-1:0] OFS_CMD     = 4'h8;
    localparam logic [OFSW-1:0] OFS_MASK1   = 4'hA;
    localparam logic [OFSW-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFSW-1:0] OFS_PTRCLR  = 4'hC;
    localparam logic [OFSW-1:0] OFS_MCLR    = 4'hD;
    localparam logic [OFSW-1:0] OFS_UNMASK  = 4'hE;
    localparam logic [OFSW-1:0] OFS_MASKALL = 4'hF;

    localparam int MODE_AUTO_BIT = 2;
    localparam int MODE_DEC_BIT  = 3;

    typedef enum logic {PTR_LO = 1'b0, PTR_HI = 1'b1} ptr_state_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_acc,
    input  logic ptr_clr,
    output logic hi_sel
);
    ptr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: if (ptr_clr) state_d = PTR_LO;
                    else if (word_acc) state_d = PTR_HI;
            PTR_HI: if (ptr_clr || word_acc) state_d = PTR_LO;
            default: state_d = PTR_LO;
        endcase
    end

    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_acc && !ptr_clr) |=> (hi_sel != $past(hi_sel)));
    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !hi_sel);
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_regs_pkg::*;
#(
    parameter int WORD_W = WW,
    parameter int BYTE_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_lo,
    input  logic              wr_addr_hi,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step_en,
    input  logic              auto_init,
    input  logic              count_down,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic              tc_pulse
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] base_addr, base_cnt;
    logic              host_wr;
    logic              do_step;

    always_comb begin
        host_wr  = wr_addr_lo | wr_addr_hi | wr_cnt_lo | wr_cnt_hi;
        do_step  = step_en & ~host_wr;
        tc_pulse = do_step && (cur_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (host_wr) begin
            if (wr_addr_lo) begin
                base_addr[BYTE_W-1:0] <= wdata;
                cur_addr[BYTE_W-1:0]  <= wdata;
            end
            if (wr_addr_hi) begin
                base_addr[WORD_W-1:BYTE_W] <= HI_W'(wdata);
                cur_addr[WORD_W-1:BYTE_W]  <= HI_W'(wdata);
            end
            if (wr_cnt_lo) begin
                base_cnt[BYTE_W-1:0] <= wdata;
                cur_cnt[BYTE_W-1:0]  <= wdata;
            end
            if (wr_cnt_hi) begin
                base_cnt[WORD_W-1:BYTE_W] <= HI_W'(wdata);
                cur_cnt[WORD_W-1:BYTE_W]  <= HI_W'(wdata);
            end
        end else if (do_step) begin
            if (tc_pulse && auto_init) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= count_down ? cur_addr - 1'b1 : cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
            end
        end
    end

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !host_wr && !(cur_cnt == '0 && auto_init))
        |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    // R11
    tc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !host_wr && cur_cnt == '0 && !auto_init)
        |=> (cur_cnt == {WORD_W{1'b1}}));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !host_wr) |=> ($stable(cur_addr) && $stable(cur_cnt)));
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_regs_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int MODE_W = MODEW,
    parameter int BYTE_W = DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_cmd,
    input  logic                     wr_mask1,
    input  logic                     wr_mode,
    input  logic                     wr_unmask,
    input  logic                     wr_maskall,
    input  logic                     mclr,
    input  logic                     rd_status,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [N_CH-1:0]          tc_in,
    output logic [N_CH-1:0]          mask_q,
    output logic [N_CH*MODE_W-1:0]   mode_flat,
    output logic [BYTE_W-1:0]        cmd_q,
    output logic [N_CH-1:0]          tc_q
);
    localparam int CSEL_W = $clog2(N_CH);

    logic [MODE_W-1:0] mode_q [N_CH];
    logic [CSEL_W-1:0] sel;

    always_comb sel = wdata[CSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            cmd_q  <= '0;
            tc_q   <= '0;
        end else begin
            if (mclr) begin
                mask_q <= '1;
                cmd_q  <= '0;
                tc_q   <= '0;
            end else begin
                if (wr_cmd)     cmd_q <= wdata;
                if (wr_mask1)   mask_q[sel] <= wdata[CSEL_W];
                if (wr_unmask)  mask_q <= '0;
                if (wr_maskall) mask_q <= wdata[N_CH-1:0];
                tc_q <= (rd_status ? '0 : tc_q) | tc_in;
            end
        end
    end

    for (genvar n = 0; n < N_CH; n++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)                          mode_q[n] <= '0;
            else if (wr_mode && sel == CSEL_W'(n)) mode_q[n] <= wdata[BYTE_W-1:BYTE_W-MODE_W];
        end
        assign mode_flat[n*MODE_W +: MODE_W] = mode_q[n];
    end

    // R8
    mask_mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask_q == '1 && cmd_q == '0 && tc_q == '0));
    // R9
    unmask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_unmask && !mclr) |=> (mask_q == '0));
    // R11
    tc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in != '0 && !mclr) |=> ((tc_q & $past(tc_in)) == $past(tc_in)));
    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && tc_in == '0) |=> (tc_q == '0));
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
    import dma_regs_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int WORD_W = WW,
    parameter int MODE_W = MODEW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               io_addr,
    input  logic [7:0]               io_wdata,
    input  logic                     io_wr,
    input  logic                     io_rd,
    output logic [7:0]               io_rdata,
    input  logic [3:0]               dreq,
    input  logic [3:0]               step,
    output logic [N_CH*WORD_W-1:0]   ch_addr,
    output logic [N_CH*MODE_W-1:0]   ch_mode,
    output logic [3:0]               ch_mask,
    output logic [7:0]               cmd_out
);
    localparam int CSEL_W = $clog2(N_CH);

    logic              wr, rd, word_port, word_acc, hi_sel;
    logic              ptr_clr, mclr;
    logic [CSEL_W-1:0] port_ch;
    logic [N_CH-1:0]   tc_vec, tc_flags;
    logic [WORD_W-1:0] cur_a [N_CH];
    logic [WORD_W-1:0] cur_c [N_CH];

    always_comb begin
        wr        = io_wr;
        rd        = io_rd & ~io_wr;
        word_port = (io_addr[3] == 1'b0);
        word_acc  = (wr | rd) & word_port;
        port_ch   = io_addr[CSEL_W:1];
        ptr_clr   = wr && (io_addr == OFS_PTRCLR || io_addr == OFS_MCLR);
        mclr      = wr && (io_addr == OFS_MCLR);
    end

    dma_byte_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_acc (word_acc),
        .ptr_clr  (ptr_clr),
        .hi_sel   (hi_sel)
    );

    dma_ctl_regs #(.N_CH(N_CH), .MODE_W(MODE_W), .BYTE_W(8)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr && io_addr == OFS_CMD),
        .wr_mask1   (wr && io_addr == OFS_MASK1),
        .wr_mode    (wr && io_addr == OFS_MODE),
        .wr_unmask  (wr && io_addr == OFS_UNMASK),
        .wr_maskall (wr && io_addr == OFS_MASKALL),
        .mclr       (mclr),
        .rd_status  (rd && io_addr == OFS_CMD),
        .wdata      (io_wdata),
        .tc_in      (tc_vec),
        .mask_q     (ch_mask),
        .mode_flat  (ch_mode),
        .cmd_q      (cmd_out),
        .tc_q       (tc_flags)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        logic hit, step_en;
        always_comb begin
            hit     = wr && word_port && (port_ch == CSEL_W'(n));
            step_en = step[n] & ~ch_mask[n];
        end

        dma_chan_bank #(.WORD_W(WORD_W), .BYTE_W(8)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr_lo (hit && !io_addr[0] && !hi_sel),
            .wr_addr_hi (hit && !io_addr[0] &&  hi_sel),
            .wr_cnt_lo  (hit &&  io_addr[0] && !hi_sel),
            .wr_cnt_hi  (hit &&  io_addr[0] &&  hi_sel),
            .wdata      (io_wdata),
            .step_en    (step_en),
            .auto_init  (ch_mode[n*MODE_W + MODE_AUTO_BIT]),
            .count_down (ch_mode[n*MODE_W + MODE_DEC_BIT]),
            .cur_addr   (cur_a[n]),
            .cur_cnt    (cur_c[n]),
            .tc_pulse   (tc_vec[n])
        );
        assign ch_addr[n*WORD_W +: WORD_W] = cur_a[n];

        // R10
        masked_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mask[n] && !(wr && word_port && port_ch == CSEL_W'(n)))
            |=> $stable(ch_addr[n*WORD_W +: WORD_W]));
    end

    always_comb begin
        logic [WORD_W-1:0] word;
        word     = io_addr[0] ? cur_c[port_ch] : cur_a[port_ch];
        io_rdata = '0;
        if (rd) begin
            if (word_port)
                io_rdata = hi_sel ? word[WORD_W-1 -: 8] : word[7:0];
            else if (io_addr == OFS_CMD)
                io_rdata = {dreq, tc_flags};
        end
    end
endmodule

// File: tb/tb_dma_host_regs.sv
module tb_dma_host_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr, io_rd;
    logic [7:0]  io_rdata;
    logic [3:0]  dreq, step;
    logic [63:0] ch_addr;
    logic [23:0] ch_mode;
    logic [3:0]  ch_mask;
    logic [7:0]  cmd_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_host_regs dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .dreq(dreq),
        .step(step), .ch_addr(ch_addr), .ch_mode(ch_mode), .ch_mask(ch_mask),
        .cmd_out(cmd_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] s);
        @(negedge clk);
        step = s;
        @(negedge clk);
        step = 4'h0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 mask", {12'h0, ch_mask}, 16'h000F);
        chk("R1 cmd", {8'h0, cmd_out}, 16'h0000);
        chk("R1 addr", ch_addr[15:0] | ch_addr[31:16] | ch_addr[47:32] | ch_addr[63:48], 16'h0);
        rd(4'h8, d);
        chk("R1 status", {8'h0, d}, 16'h0000);
        rd(4'h1, d);
        chk("R1 count low byte first", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_word_access();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        wr(4'h4, 8'h34); wr(4'h4, 8'h12);
        chk("R2 R4 ch2 addr", ch_addr[47:32], 16'h1234);
        wr(4'h5, 8'h02); wr(4'h5, 8'h00);
        wr(4'hC, 8'h00);
        rd(4'h4, d); chk("R2 addr lo read", {8'h0, d}, 16'h0034);
        rd(4'h4, d); chk("R2 addr hi read", {8'h0, d}, 16'h0012);
        rd(4'h5, d); chk("R2 cnt lo read", {8'h0, d}, 16'h0002);
        rd(4'h5, d); chk("R2 cnt hi read", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_ptr_clear();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        wr(4'h0, 8'hAA);
        wr(4'hC, 8'h77);
        wr(4'h0, 8'hBB); wr(4'h0, 8'h01);
        chk("R3 mid-word clear", ch_addr[15:0], 16'h01BB);
        rd(4'h0, d);
        wr(4'hC, 8'h00);
        rd(4'h0, d); chk("R3 clear after read", {8'h0, d}, 16'h00BB);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_masks();
        wr(4'hE, 8'h00); chk("R9 clear all", {12'h0, ch_mask}, 16'h0000);
        wr(4'hA, 8'h06); chk("R5 mask ch2", {12'h0, ch_mask}, 16'h0004);
        wr(4'hA, 8'h02); chk("R5 unmask ch2", {12'h0, ch_mask}, 16'h0000);
        wr(4'hF, 8'h5A); chk("R9 write all", {12'h0, ch_mask}, 16'h000A);
        wr(4'hE, 8'h00);
    endtask

    task automatic t_modes();
        wr(4'hB, 8'hC1); chk("R6 ch1 cascade", {10'h0, ch_mode[11:6]}, 16'h0030);
        wr(4'hB, 8'h12); chk("R6 ch2 auto", {10'h0, ch_mode[17:12]}, 16'h0004);
        chk("R6 ch1 kept", {10'h0, ch_mode[11:6]}, 16'h0030);
    endtask

    task automatic t_cmd_status();
        logic [7:0] d;
        wr(4'h8, 8'h5A); chk("R7 cmd", {8'h0, cmd_out}, 16'h005A);
        dreq = 4'b1010;
        rd(4'h8, d); chk("R7 dreq in status", {8'h0, d}, 16'h00A0);
        dreq = 4'b0000;
    endtask

    task automatic t_steps();
        logic [7:0] d, e;
        pulse(4'b0100);
        chk("R10 ch2 addr up", ch_addr[47:32], 16'h1235);
        wr(4'hC, 8'h00); rd(4'h5, d); rd(4'h5, e);
        chk("R10 ch2 count down", {e, d}, 16'h0001);
        pulse(4'b0100); pulse(4'b0100);
        chk("R11 auto reload addr", ch_addr[47:32], 16'h1234);
        rd(4'h5, d); rd(4'h5, e);
        chk("R11 auto reload count", {e, d}, 16'h0002);
        rd(4'h8, d); chk("R11 tc flag ch2", {8'h0, d}, 16'h0004);
        rd(4'h8, d); chk("R7 status cleared by read", {8'h0, d}, 16'h0000);
        wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        pulse(4'b0001);
        chk("R10 ch0 addr up", ch_addr[15:0], 16'h01BC);
        rd(4'h1, d); rd(4'h1, e);
        chk("R11 wrap to FFFF", {e, d}, 16'hFFFF);
        rd(4'h8, d); chk("R11 tc flag ch0", {8'h0, d}, 16'h0001);
        wr(4'h6, 8'h10); wr(4'h6, 8'h00);
        wr(4'hB, 8'h23);
        pulse(4'b1000);
        chk("R10 ch3 addr down", ch_addr[63:48], 16'h000F);
        wr(4'hA, 8'h07);
        pulse(4'b1000);
        chk("R10 masked step ignored", ch_addr[63:48], 16'h000F);
    endtask

    task automatic t_mclr();
        logic [7:0] d;
        wr(4'hC, 8'h00);
        wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        pulse(4'b0001);
        rd(4'h4, d);
        wr(4'hD, 8'h00);
        chk("R8 masks set", {12'h0, ch_mask}, 16'h000F);
        chk("R8 cmd cleared", {8'h0, cmd_out}, 16'h0000);
        chk("R8 addr kept", ch_addr[47:32], 16'h1234);
        chk("R8 mode kept", {10'h0, ch_mode[17:12]}, 16'h0004);
        rd(4'hD, d); chk("R8 temp reads zero", {8'h0, d}, 16'h0000);
        rd(4'h8, d); chk("R8 tc cleared", {8'h0, d}, 16'h0000);
        rd(4'h4, d); chk("R8 pointer low", {8'h0, d}, 16'h0034);
        rd(4'h4, d); chk("R8 pointer then high", {8'h0, d}, 16'h0012);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; io_addr = 4'h0; io_wdata = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
        dreq = 4'h0; step = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_access();
        t_ptr_clear();
        t_masks();
        t_modes();
        t_cmd_status();
        t_steps();
        t_mclr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule